// File: doc/BRIEF.md
# Grouped Lookahead Adder/Subtractor

This block adds or subtracts two unsigned or two's-complement operands in a single combinational pass. A one-bit mode input picks the operation. In add mode the second operand goes through unchanged and the carry-in is zero. In subtract mode every bit of the second operand is inverted and the carry-in is forced to one, so the block forms the first operand plus the two's complement of the second.

The operand width is split into 4-bit slices. Each slice first forms a propagate term and a generate term for every bit. It then computes each internal carry, and its own carry-out, as a flat two-level sum of products of those terms and the slice's carry-in. Each sum bit is the XOR of the propagate term and the carry into that bit. Slices are chained only through their carry-out, so a carry crosses the word one slice at a time rather than one bit at a time.

The result comes with a carry-out and a signed overflow flag. The overflow flag is the XOR of the carry into the top bit and the carry out of it. In subtract mode the carry-out reads as "no borrow". The block contains no registers and no latches.

Top module: `addsub_cla`

## Requirements
- R1: With subMode=0, {carryOut, result} equals the (WIDTH+1)-bit unsigned sum opA + opB.
- R2: With subMode=1, result equals (opA - opB) mod 2^WIDTH, and carryOut is 1 exactly when opA >= opB as unsigned numbers, meaning no borrow.
- R3: With subMode=0, overflow is 1 exactly when the signed sum of opA and opB lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1].
- R4: With subMode=1, overflow is 1 exactly when the signed difference opA - opB lies outside [-2^(WIDTH-1), 2^(WIDTH-1)-1].
- R5: A carry that one 4-bit slice generates or propagates reaches every slice above it. For example, an all-ones opA plus 1 gives a zero result with carryOut=1.
- R6: The outputs are a pure function of the present inputs. A change on subMode alone shows up on the outputs with no clock edge.
- R7: Subtracting equal operands gives a zero result, carryOut=1 and overflow=0.
- R8: The subtract boundaries hold. 0 - 1 gives an all-ones result with carryOut=0 and overflow=0. The most negative value minus 1 sets overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | First operand, or the minuend in subtract mode |
| opB | input | WIDTH | Second operand, or the subtrahend in subtract mode |
| subMode | input | 1 | 0 selects add, 1 selects subtract |
| result | output | WIDTH | Sum or difference, modulo 2^WIDTH |
| carryOut | output | 1 | Carry out of the top bit; in subtract mode, 1 means no borrow |
| overflow | output | 1 | Signed overflow of the operation |

## Verification
The bench builds two copies of the block, one with WIDTH=8 and one with WIDTH=16. The 8-bit copy is driven through every operand pair in both modes. That covers every combination of slice carry-in, propagate and generate patterns, and every overflow case, in both slices and across the slice boundary. The 16-bit copy receives directed boundary operands and then a random pair on every cycle of that sweep. This exercises a chain of four slices, where a carry has to cross three slice boundaries.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
  localparam int GROUP_BITS = 4;

  // Strobes the mode decode hands to the datapath
  typedef struct packed {
    logic invertB;
    logic carryIn;
  } addStrobes_t;
endpackage

// File: rtl/addsub_ctrl.sv
module addsub_ctrl
  import addsub_pkg::*;
(
  input  logic        subMode,
  output addStrobes_t strobes
);
  // Subtraction is A + ~B + 1: both strobes follow the mode bit
  always_comb begin
    strobes.invertB = subMode;
    strobes.carryIn = subMode;
  end
endmodule

// File: rtl/cla_group.sv
module cla_group
  import addsub_pkg::*;
#(
  parameter bit IS_TOP = 1'b0
) (
  input  logic [GROUP_BITS-1:0] a,
  input  logic [GROUP_BITS-1:0] b,
  input  logic                  cIn,
  output logic [GROUP_BITS-1:0] sum,
  output logic                  cOut,
  output logic                  signOvf
);
  logic [GROUP_BITS-1:0] p;
  logic [GROUP_BITS-1:0] g;
  logic [GROUP_BITS-1:0] c;

  assign p = a ^ b;
  assign g = a & b;

  // Every carry is a flat sum of products in terms of cIn only
  always_comb begin
    c[0] = cIn;
    c[1] = g[0] | (p[0] & cIn);
    c[2] = g[1] | (p[1] & g[0]) | (p[1] & p[0] & cIn);
    c[3] = g[2] | (p[2] & g[1]) | (p[2] & p[1] & g[0])
         | (p[2] & p[1] & p[0] & cIn);
    cOut = g[3] | (p[3] & g[2]) | (p[3] & p[2] & g[1])
         | (p[3] & p[2] & p[1] & g[0])
         | (p[3] & p[2] & p[1] & p[0] & cIn);
  end

  assign sum = p ^ c;

  // Only the slice holding the sign bit reports overflow
  generate
    if (IS_TOP) begin : g_topOvf
      assign signOvf = c[3] ^ cOut;
    end else begin : g_noOvf
      assign signOvf = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/addsub_datapath.sv
module addsub_datapath
  import addsub_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  addStrobes_t      strobes,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             overflow
);
  localparam int NUM_GROUPS = WIDTH / GROUP_BITS;

  logic [WIDTH-1:0]      bCond;
  logic [NUM_GROUPS:0]   groupCarry;
  logic [NUM_GROUPS-1:0] ovfVec;

  assign bCond         = opB ^ {WIDTH{strobes.invertB}};
  assign groupCarry[0] = strobes.carryIn;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_GROUPS; gi++) begin : g_slice
      cla_group #(
        .IS_TOP(gi == NUM_GROUPS - 1)
      ) u_grp (
        .a      (opA[gi*GROUP_BITS +: GROUP_BITS]),
        .b      (bCond[gi*GROUP_BITS +: GROUP_BITS]),
        .cIn    (groupCarry[gi]),
        .sum    (result[gi*GROUP_BITS +: GROUP_BITS]),
        .cOut   (groupCarry[gi+1]),
        .signOvf(ovfVec[gi])
      );
    end
  endgenerate

  assign carryOut = groupCarry[NUM_GROUPS];
  assign overflow = |ovfVec;
endmodule

// File: rtl/addsub_cla.sv
module addsub_cla
  import addsub_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  input  logic             subMode,
  output logic [WIDTH-1:0] result,
  output logic             carryOut,
  output logic             overflow
);
  addStrobes_t strobes;

  addsub_ctrl u_ctrl (
    .subMode(subMode),
    .strobes(strobes)
  );

  addsub_datapath #(
    .WIDTH(WIDTH)
  ) u_dp (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .result  (result),
    .carryOut(carryOut),
    .overflow(overflow)
  );
endmodule

// File: rtl/addsub_cla_chk.sv
module addsub_cla_chk #(
  parameter int N = 16
) (
  input logic [N-1:0] opA,
  input logic [N-1:0] opB,
  input logic         subMode,
  input logic [N-1:0] result,
  input logic         carryOut,
  input logic         overflow
);
  always_comb begin
    if (!subMode) begin
      p_add_sum_r1: assert ({carryOut, result} == ({1'b0, opA} + {1'b0, opB}));
      p_add_ovf_r3: assert (overflow == ((opA[N-1] == opB[N-1]) && (result[N-1] != opA[N-1])));
    end else begin
      p_sub_diff_r2: assert ((result == N'(opA - opB)) && (carryOut == (opA >= opB)));
      p_sub_ovf_r4: assert (overflow == ((opA[N-1] != opB[N-1]) && (result[N-1] != opA[N-1])));
      if (opA == opB) begin
        p_sub_equal_r7: assert ((result == '0) && carryOut && !overflow);
      end
    end
  end
endmodule

bind addsub_cla addsub_cla_chk #(.N(WIDTH)) u_chk (
  .opA     (opA),
  .opB     (opB),
  .subMode (subMode),
  .result  (result),
  .carryOut(carryOut),
  .overflow(overflow)
);

// File: tb/sim_addsub_cla.sv
module sim_addsub_cla;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [15:0] a16 = '0, b16 = '0;
  logic        m16 = 1'b0;
  logic [15:0] r16;
  logic        co16, ov16;

  logic [7:0]  a8 = '0, b8 = '0;
  logic        m8 = 1'b0;
  logic [7:0]  r8;
  logic        co8, ov8;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  addsub_cla #(.WIDTH(16)) u0 (
    .opA(a16), .opB(b16), .subMode(m16),
    .result(r16), .carryOut(co16), .overflow(ov16)
  );

  addsub_cla #(.WIDTH(8)) u1 (
    .opA(a8), .opB(b8), .subMode(m8),
    .result(r8), .carryOut(co8), .overflow(ov8)
  );

  // Behavioural reference on plain integers
  task automatic compare(input string tag, input int w, input longint a, input longint b,
                         input bit m, input longint res, input bit co, input bit ov);
    longint mask, half, full, expRes, sa, sb, sr;
    bit expCo, expOv;
    string rTag, oTag;
    mask = (longint'(1) << w) - 1;
    half = longint'(1) << (w - 1);
    full = a + (m ? (~b & mask) : b) + (m ? 1 : 0);
    expRes = full & mask;
    expCo = ((full >> w) & 1) != 0;
    sa = (a >= half) ? a - (mask + 1) : a;
    sb = (b >= half) ? b - (mask + 1) : b;
    sr = m ? sa - sb : sa + sb;
    expOv = (sr > half - 1) || (sr < -half);
    rTag = (tag != "") ? tag : (m ? "R2" : "R1");
    oTag = (tag != "") ? tag : (m ? "R4" : "R3");
    checks++;
    if (res != expRes || co != expCo) begin
      failures++;
      $display("FAIL %s w=%0d a=%0h b=%0h m=%0d: actual %0h/%0d expected %0h/%0d",
               rTag, w, a, b, m, res, co, expRes, expCo);
    end
    checks++;
    if (ov != expOv) begin
      failures++;
      $display("FAIL %s w=%0d a=%0h b=%0h m=%0d overflow: actual %0d expected %0d",
               oTag, w, a, b, m, ov, expOv);
    end
  endtask

  task automatic apply16(input logic [15:0] a, input logic [15:0] b, input bit m,
                         input string tag);
    @(posedge clk);
    a16 = a; b16 = b; m16 = m;
    @(negedge clk);
    compare(tag, 16, a16, b16, m16, r16, co16, ov16);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // Reset state: zero operands in add mode give all-zero outputs (R1)
    compare("R1", 16, a16, b16, m16, r16, co16, ov16);
    compare("R1", 8, a8, b8, m8, r8, co8, ov8);
    rst = 1'b0;

    apply16(16'hFFFF, 16'h0001, 1'b0, "R5");
    apply16(16'h000F, 16'h0001, 1'b0, "R5");
    apply16(16'h0FFF, 16'h0001, 1'b0, "R5");
    apply16(16'h00FF, 16'h0F01, 1'b0, "R5");
    apply16(16'h1234, 16'h1234, 1'b1, "R7");
    apply16(16'h8000, 16'h8000, 1'b1, "R7");
    apply16(16'h0000, 16'h0001, 1'b1, "R8");
    apply16(16'h8000, 16'h0001, 1'b1, "R8");
    apply16(16'h7FFF, 16'h0001, 1'b0, "R3");
    apply16(16'h8000, 16'hFFFF, 1'b0, "R3");
    apply16(16'h7FFF, 16'hFFFF, 1'b1, "R4");

    // R6: flip only the mode between clock edges and look 1 ns later
    @(negedge clk);
    a16 = 16'h0005; b16 = 16'h0003; m16 = 1'b0;
    #1 compare("R6", 16, a16, b16, m16, r16, co16, ov16);
    m16 = 1'b1;
    #1 compare("R6", 16, a16, b16, m16, r16, co16, ov16);

    // Every 8-bit pair in both modes, a random 16-bit pair alongside
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 256; a++) begin
        for (int b = 0; b < 256; b++) begin
          @(posedge clk);
          a8 = 8'(a); b8 = 8'(b); m8 = m[0];
          a16 = 16'($urandom); b16 = 16'($urandom); m16 = $urandom % 2;
          @(negedge clk);
          compare("", 8, a8, b8, m8, r8, co8, ov8);
          compare("", 16, a16, b16, m16, r16, co16, ov16);
        end
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule